// File: doc/BRIEF.md
# Debug Address Breakpoint Qualifier

This block watches the program address bus and the primary data address bus of a processor core. Each cycle it decides whether the current bus activity matches a programmed breakpoint address and belongs to the class of access that debug control has selected. When both hold, it raises an event pulse one cycle later. Two 2-bit control fields drive the decision. A select field picks the bus and access class: executed instruction fetch, any program memory access, or the primary data bus. An enable field picks the direction, or switches every breakpoint off.

A second comparator watches executed instruction fetches against its own address. It does not decode select or direction. It is silenced only when the enable field is zero. The secondary data bus, used for the second read of a dual-read instruction, is not wired into the block, so it can never cause an event. The control fields and breakpoint addresses come from a debug register file outside the block, and that file clears the fields on hardware reset. The halt sequence that consumes the events is also outside the block.

Top module: `bkpt_qualifier`

## Requirements
- R1: When `brk_en` is 00, neither `bp1_evt` nor `bp2_evt` ever asserts, whatever `brk_sel`, the strobes and the addresses hold.
- R2: With `brk_sel`=00 and `brk_en`=10, `bp1_evt` fires only for an executed first-word fetch at `bp1_addr`. An executed first-word fetch is `prog_fetch`=1 with `fetch_killed`, `fetch_word2` and `fetch_untaken` all 0. Program data moves never fire in this mode.
- R3: With `brk_sel`=01, any program-side fetch at `bp1_addr` fires, including killed, second-word and untaken-jump fetches. A program data move fires as follows: with `brk_en`=01 only a write (`prog_mv_wr`); with 10 only a read (`prog_mv_rd`); with 11 either.
- R4: With `brk_sel`=10, only the primary data bus is compared. `brk_en`=01 fires on `dat1_wr`, 10 on `dat1_rd`, and 11 on either, when `dat1_addr` equals `bp1_addr`. Program-side activity is ignored in this mode.
- R5: The reserved codes never fire `bp1_evt`. These are `brk_sel`=00 with `brk_en` of 01 or 11, and `brk_sel`=11 with any `brk_en`.
- R6: `bp2_evt` fires for an executed first-word fetch whose `prog_addr` equals `bp2_addr`, whenever `brk_en` is nonzero, whatever `brk_sel` holds.
- R7: While `rst_n` is low both events are low. They stay low through the two clock edges that release the internal reset.
- R8: Address comparison is exact equality over all `AW` bits. An address that differs in a single bit never fires.
- R9: Each event is registered. It is high in exactly the cycle after a qualifying access and low in the next cycle if no qualifying access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| brk_sel | input | 2 | Bus and access class select |
| brk_en | input | 2 | Direction enable; 00 disables all comparators |
| bp1_addr | input | AW | Address for comparator 1 |
| bp2_addr | input | AW | Address for comparator 2 |
| prog_addr | input | AW | Program address bus |
| prog_fetch | input | 1 | Program bus carries an instruction fetch this cycle |
| fetch_killed | input | 1 | The fetch is discarded |
| fetch_word2 | input | 1 | The fetch is a second instruction word |
| fetch_untaken | input | 1 | The fetch is a jump that is not taken |
| prog_mv_rd | input | 1 | Data move reads program memory |
| prog_mv_wr | input | 1 | Data move writes program memory |
| dat1_addr | input | AW | Primary data address bus |
| dat1_rd | input | 1 | Primary data bus read |
| dat1_wr | input | 1 | Primary data bus write |
| bp1_evt | output | 1 | Comparator 1 event pulse |
| bp2_evt | output | 1 | Comparator 2 event pulse |

## Verification
The bench sweeps all sixteen control codes against each single access kind with every address matching. This exposes a design that lets a killed, second-word or untaken-jump fetch through in executed-fetch mode, and one that confuses read and write in the program or data modes. The same sweep catches a reserved code that leaks an event, and a comparator 2 that either ignores the global disable or wrongly obeys the select field. Single-bit address misses catch a partial-width compare. An isolated access followed by an idle cycle catches an event that is late or sticks high. A reset asserted mid-stream catches a register that is not cleared asynchronously.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    SEL_EXEC_FETCH = 2'b00,
    SEL_PROG_ANY   = 2'b01,
    SEL_DATA1      = 2'b10,
    SEL_RSVD       = 2'b11
  } bk_sel_e;

  typedef enum logic [1:0] {
    EN_OFF = 2'b00,
    EN_WR  = 2'b01,
    EN_RD  = 2'b10,
    EN_ANY = 2'b11
  } bk_en_e;

  typedef struct packed {
    logic fetch;
    logic killed;
    logic word2;
    logic untaken;
    logic mv_rd;
    logic mv_wr;
  } pcyc_t;

  typedef struct packed {
    logic rd;
    logic wr;
  } dcyc_t;

endpackage

// File: rtl/bkpt_addr_eq.sv
module bkpt_addr_eq #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] lhs,
  input  logic [AW-1:0] rhs,
  output logic          eq
);
  logic [AW-1:0] diff;

  always_comb begin
    diff = lhs ^ rhs;
    eq   = ~|diff;
  end
endmodule

// File: rtl/bkpt_class_decode.sv
module bkpt_class_decode
  import bkpt_pkg::*;
(
  input  bk_sel_e sel,
  input  bk_en_e  en,
  input  pcyc_t   pcyc,
  input  dcyc_t   dcyc,
  output logic    prog_qual,
  output logic    data_qual,
  output logic    exec_fetch
);
  logic want_wr;
  logic want_rd;

  always_comb begin
    exec_fetch = pcyc.fetch & ~pcyc.killed & ~pcyc.word2 & ~pcyc.untaken;
    want_wr    = (en == EN_WR) | (en == EN_ANY);
    want_rd    = (en == EN_RD) | (en == EN_ANY);
    prog_qual  = 1'b0;
    data_qual  = 1'b0;
    if (en != EN_OFF) begin
      case (sel)
        SEL_EXEC_FETCH: prog_qual = (en == EN_RD) & exec_fetch;
        SEL_PROG_ANY:   prog_qual = pcyc.fetch | (want_wr & pcyc.mv_wr)
                                               | (want_rd & pcyc.mv_rd);
        SEL_DATA1:      data_qual = (want_wr & dcyc.wr) | (want_rd & dcyc.rd);
        default: begin
          prog_qual = 1'b0;
          data_qual = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bkpt_evt_reg.sv
module bkpt_evt_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic evt
);
  logic evt_q;
  logic evt_d;
  logic upd_en;

  always_comb begin
    upd_en = hit | evt_q;
    evt_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= 1'b0;
    else if (upd_en) evt_q <= evt_d;
  end

  assign evt = evt_q;
endmodule

// File: rtl/bkpt_qualifier.sv
module bkpt_qualifier
  import bkpt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    brk_sel,
  input  logic [1:0]    brk_en,
  input  logic [AW-1:0] bp1_addr,
  input  logic [AW-1:0] bp2_addr,
  input  logic [AW-1:0] prog_addr,
  input  logic          prog_fetch,
  input  logic          fetch_killed,
  input  logic          fetch_word2,
  input  logic          fetch_untaken,
  input  logic          prog_mv_rd,
  input  logic          prog_mv_wr,
  input  logic [AW-1:0] dat1_addr,
  input  logic          dat1_rd,
  input  logic          dat1_wr,
  output logic          bp1_evt,
  output logic          bp2_evt
);
  localparam int NCMP = 3;
  localparam int NEVT = 2;

  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pcyc_t pcyc;
  dcyc_t dcyc;
  logic  prog_qual, data_qual, exec_fetch;

  always_comb begin
    pcyc = '{fetch: prog_fetch, killed: fetch_killed, word2: fetch_word2,
             untaken: fetch_untaken, mv_rd: prog_mv_rd, mv_wr: prog_mv_wr};
    dcyc = '{rd: dat1_rd, wr: dat1_wr};
  end

  bkpt_class_decode u_decode (
    .sel        (bk_sel_e'(brk_sel)),
    .en         (bk_en_e'(brk_en)),
    .pcyc       (pcyc),
    .dcyc       (dcyc),
    .prog_qual  (prog_qual),
    .data_qual  (data_qual),
    .exec_fetch (exec_fetch)
  );

  logic [NCMP-1:0][AW-1:0] cmp_lhs, cmp_rhs;
  logic [NCMP-1:0]         cmp_eq;

  always_comb begin
    cmp_lhs[0] = prog_addr; cmp_rhs[0] = bp1_addr;
    cmp_lhs[1] = dat1_addr; cmp_rhs[1] = bp1_addr;
    cmp_lhs[2] = prog_addr; cmp_rhs[2] = bp2_addr;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    bkpt_addr_eq #(.AW(AW)) u_eq (
      .lhs (cmp_lhs[g]),
      .rhs (cmp_rhs[g]),
      .eq  (cmp_eq[g])
    );
  end

  logic [NEVT-1:0] hit, evt;

  always_comb begin
    hit[0] = (prog_qual & cmp_eq[0]) | (data_qual & cmp_eq[1]);
    hit[1] = (brk_en != 2'b00) & exec_fetch & cmp_eq[2];
  end

  for (genvar e = 0; e < NEVT; e++) begin : g_evt
    bkpt_evt_reg u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .hit   (hit[e]),
      .evt   (evt[e])
    );
  end

  assign bp1_evt = evt[0];
  assign bp2_evt = evt[1];

  p_global_off_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bp1_evt || bp2_evt) |-> ($past(brk_en) != 2'b00));

  p_exec_only_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bp1_evt && $past(brk_sel) == 2'b00) |->
      $past(prog_fetch && !fetch_killed && !fetch_word2 && !fetch_untaken));

  p_data_dir_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bp1_evt && $past(brk_sel) == 2'b10) |->
      ($past(dat1_addr) == $past(bp1_addr) && $past(dat1_rd || dat1_wr)));

  p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bp1_evt |-> ($past(brk_sel) != 2'b11 &&
                 !($past(brk_sel) == 2'b00 && $past(brk_en) != 2'b10)));

  p_bp2_match_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bp2_evt |-> ($past(prog_addr) == $past(bp2_addr) && $past(prog_fetch)));

  p_prog_match_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bp1_evt && ($past(brk_sel) == 2'b00 || $past(brk_sel) == 2'b01)) |->
      ($past(prog_addr) == $past(bp1_addr)));

endmodule

// File: tb/bkpt_qualifier_tb.sv
`timescale 1ns/1ps
module bkpt_qualifier_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    brk_sel, brk_en;
  logic [AW-1:0] bp1_addr, bp2_addr, prog_addr, dat1_addr;
  logic          prog_fetch, fetch_killed, fetch_word2, fetch_untaken;
  logic          prog_mv_rd, prog_mv_wr, dat1_rd, dat1_wr;
  logic          bp1_evt, bp2_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bkpt_qualifier #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .brk_sel(brk_sel), .brk_en(brk_en),
    .bp1_addr(bp1_addr), .bp2_addr(bp2_addr), .prog_addr(prog_addr),
    .prog_fetch(prog_fetch), .fetch_killed(fetch_killed),
    .fetch_word2(fetch_word2), .fetch_untaken(fetch_untaken),
    .prog_mv_rd(prog_mv_rd), .prog_mv_wr(prog_mv_wr),
    .dat1_addr(dat1_addr), .dat1_rd(dat1_rd), .dat1_wr(dat1_wr),
    .bp1_evt(bp1_evt), .bp2_evt(bp2_evt)
  );

  function automatic bit ref_bp1();
    bit exe = prog_fetch && !fetch_killed && !fetch_word2 && !fetch_untaken;
    bit pm  = (prog_addr == bp1_addr);
    bit dm  = (dat1_addr == bp1_addr);
    if (brk_en == 2'b00) return 0;
    case (brk_sel)
      2'b00: return (brk_en == 2'b10) && exe && pm;
      2'b01: begin
        if (brk_en == 2'b01) return pm && (prog_fetch || prog_mv_wr);
        if (brk_en == 2'b10) return pm && (prog_fetch || prog_mv_rd);
        return pm && (prog_fetch || prog_mv_rd || prog_mv_wr);
      end
      2'b10: begin
        if (brk_en == 2'b01) return dm && dat1_wr;
        if (brk_en == 2'b10) return dm && dat1_rd;
        return dm && (dat1_rd || dat1_wr);
      end
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_bp2();
    return (brk_en != 2'b00) && prog_fetch && !fetch_killed && !fetch_word2
           && !fetch_untaken && (prog_addr == bp2_addr);
  endfunction

  function automatic string tag_bp1();
    if (brk_en == 2'b00) return "R1";
    if (brk_sel == 2'b11 || (brk_sel == 2'b00 && brk_en != 2'b10)) return "R5";
    if (brk_sel == 2'b00) return "R2";
    if (brk_sel == 2'b01) return "R3";
    return "R4";
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    prog_fetch = 0; fetch_killed = 0; fetch_word2 = 0; fetch_untaken = 0;
    prog_mv_rd = 0; prog_mv_wr = 0; dat1_rd = 0; dat1_wr = 0;
  endtask

  // inputs are set at a falling edge; the result is checked one cycle later
  task automatic step(input string t1, input string t2);
    bit e1 = ref_bp1();
    bit e2 = ref_bp2();
    @(negedge clk);
    chk(bp1_evt, e1, t1);
    chk(bp2_evt, e2, t2);
  endtask

  task automatic set_kind(input int k);
    idle_bus();
    case (k)
      0: prog_fetch = 1;
      1: begin prog_fetch = 1; fetch_killed = 1; end
      2: begin prog_fetch = 1; fetch_word2 = 1; end
      3: begin prog_fetch = 1; fetch_untaken = 1; end
      4: prog_mv_rd = 1;
      5: prog_mv_wr = 1;
      6: dat1_rd = 1;
      default: dat1_wr = 1;
    endcase
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    rst_n = 0; brk_sel = 0; brk_en = 0;
    bp1_addr = 16'h1234; bp2_addr = 16'h4321;
    prog_addr = 0; dat1_addr = 0; idle_bus();
    repeat (3) @(negedge clk);
    chk(bp1_evt, 0, "R7"); chk(bp2_evt, 0, "R7");
    rst_n = 1;
    brk_sel = 2'b01; brk_en = 2'b11; prog_addr = bp1_addr; prog_fetch = 1;
    @(negedge clk);
    chk(bp1_evt, 0, "R7");
    @(negedge clk);
    chk(bp1_evt, 0, "R7");
    idle_bus();
    repeat (2) @(negedge clk);

    // exhaustive control codes against each access kind, all addresses matching
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 4; e++)
        for (int k = 0; k < 8; k++) begin
          brk_sel = s[1:0]; brk_en = e[1:0];
          prog_addr = bp1_addr; dat1_addr = bp1_addr;
          set_kind(k);
          step(tag_bp1(), "R1");
          bp2_addr = bp1_addr;
          step(tag_bp1(), (e == 0) ? "R1" : "R6");
          bp2_addr = 16'h4321;
        end

    // R8: single-bit misses in each mode
    for (int b = 0; b < AW; b += 5) begin
      brk_en = 2'b11; brk_sel = 2'b01; set_kind(0);
      prog_addr = bp1_addr ^ (16'h1 << b);
      step("R8", "R8");
      brk_sel = 2'b10; set_kind(6);
      dat1_addr = bp1_addr ^ (16'h1 << b);
      step("R8", "R8");
    end

    // R9: isolated access then idle
    brk_sel = 2'b00; brk_en = 2'b10; prog_addr = bp1_addr; set_kind(0);
    step("R9", "R9");
    chk(bp1_evt, 1, "R9");
    idle_bus();
    step("R9", "R9");
    chk(bp1_evt, 0, "R9");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 3);
      brk_sel = 2'($urandom); brk_en = 2'($urandom);
      prog_addr = (pick == 0) ? bp1_addr : (pick == 1) ? bp2_addr :
                  (pick == 2) ? bp1_addr ^ 16'h0001 : 16'($urandom);
      dat1_addr = ($urandom_range(0, 1) == 1) ? bp1_addr : 16'($urandom);
      prog_fetch = ($urandom_range(0, 9) < 5);
      fetch_killed = ($urandom_range(0, 9) < 2);
      fetch_word2 = ($urandom_range(0, 9) < 2);
      fetch_untaken = ($urandom_range(0, 9) < 2);
      prog_mv_rd = ($urandom_range(0, 9) < 3);
      prog_mv_wr = ($urandom_range(0, 9) < 3);
      dat1_rd = ($urandom_range(0, 9) < 4);
      dat1_wr = ($urandom_range(0, 9) < 4);
      step(tag_bp1(), (brk_en == 0) ? "R1" : "R6");
    end

    // R7: reset asserted mid-stream clears the events at once
    brk_sel = 2'b00; brk_en = 2'b10; prog_addr = bp1_addr; bp2_addr = bp1_addr;
    set_kind(0);
    @(negedge clk);
    chk(bp1_evt, 1, "R7");
    #1 rst_n = 0;
    #0.5;
    chk(bp1_evt, 0, "R7"); chk(bp2_evt, 0, "R7");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bp1_evt, 0, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule